// File: doc/BRIEF.md
# Debug Probe Detect and Reset Hold

This block decides whether the CPU may leave reset once the system reset has ended, and records whether a debug probe has been attached. When the debug clock pin is low at the moment the power-on or external reset ends, the block keeps the CPU in reset. This extended hold lasts until the debugger writes a release command. That same event counts as a cold-plug detection. While the system runs, a falling edge on the debug clock pin counts as a hot-plug detection.

A security-lock input blocks the release command. An attempt made while the lock is set leaves the CPU held and sets a sticky protection-error flag. If the pin is switched away from its debug function, hot-plug detection turns off. It stays off until the next power-on or external reset, and a readable status bit shows whether it is still on.

Software or the debugger reaches the status through a small write port and a registered read port.

Top module: `dbg_attach_hold`

## Requirements
- R1: While `por_i` or `ext_rst_i` is high, `cpu_reset_o` is 1 from the next clock edge on. Reset returns the status to: hold flag 0, error 0, probe present 0, hot-plug available 1, with `rd_data_o` at 0.
- R2: The debug clock pin passes through SYNC_STAGES flops. It is sampled in the first cycle after reset ends. If that sample is low, the hold flag (address 0, bit 0) is set and `cpu_reset_o` stays 1. If it is high, `cpu_reset_o` falls at that first edge.
- R3: With `sec_lock_i` low, a write to address 0 with bit 0 set clears the hold flag. `cpu_reset_o` falls at the same edge that performs the write.
- R4: A write to address 0 with bit 0 clear leaves the hold flag and `cpu_reset_o` unchanged.
- R5: With `sec_lock_i` high, a write of 1 to address 0 bit 0 leaves the hold flag and `cpu_reset_o` as they were. It sets the protection-error flag (address 0, bit 1).
- R6: Writing 1 to address 0 bit 1 clears the protection-error flag, and writing 0 there leaves it alone. If one write both sets the flag (R5) and clears it, the flag ends up set.
- R7: Setting the hold flag at reset release also sets the probe-present bit (address 1, bit 0).
- R8: Outside reset, a falling edge of the synchronised debug clock pin sets probe-present when hot-plug is available and the pin is selected for debug. Such an edge does not hold the CPU.
- R9: If `dbg_pin_sel_i` is seen low in any cycle outside reset, the hot-plug-available bit (address 1, bit 1) becomes 0. It stays 0, and falling edges are ignored, until the next power-on or external reset.
- R10: Probe-present is cleared only by reset. Writes to address 1 change nothing.
- R11: `rd_data_o` shows the register selected by `rd_addr_i` one clock later. Unused bits and unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| ext_rst_i | input | 1 | External reset, active high, synchronous |
| dbg_clk_i | input | 1 | Debug clock pin level (asynchronous) |
| dbg_pin_sel_i | input | 1 | 1 when the pin carries its debug function |
| sec_lock_i | input | 1 | Security lock; blocks the release command |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Registered read data |
| cpu_reset_o | output | 1 | CPU reset (hold) output, active high |

## Verification
A single write to address 0 can land a release command and an error-clear in the same cycle. The bench walks every combination of pin level at reset release, lock level and two consecutive 2-bit write values. For each combination it computes the expected hold flag, error flag and CPU reset from the rules: set beats clear, and a release blocked by the lock leaves the hold in place. It then compares them with the read port and `cpu_reset_o`. Hot plug is tested in a second collision: a falling edge that arrives after a pin-function change must be ignored. A later reset must make hot plug available again.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  localparam int unsigned ADR_CTRL   = 0;
  localparam int unsigned ADR_STAT   = 1;
  localparam int unsigned BIT_HOLD   = 0;
  localparam int unsigned BIT_PERR   = 1;
  localparam int unsigned BIT_PRES   = 0;
  localparam int unsigned BIT_HPAV   = 1;
endpackage

// File: rtl/dpd_pin_sync.sv
module dpd_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_i,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // free-running synchroniser stages; the detector after them is reset
  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) chain_q[gi] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk) chain_q[gi] <= chain_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = prev_q & ~chain_q[STAGES-1];

  assert_fall_after_high_R8: assert property (@(posedge clk) disable iff (rst_i)
    fall_o |-> $past(chain_q[STAGES-1]));
endmodule

// File: rtl/dpd_hold_ctrl.sv
module dpd_hold_ctrl (
  input  logic clk,
  input  logic rst_i,
  input  logic first_i,
  input  logic pin_low_i,
  input  logic lock_i,
  input  logic wr_ctrl_i,
  input  logic wr_rel_i,
  input  logic wr_clr_i,
  output logic hold_o,
  output logic hold_d_o,
  output logic err_o,
  output logic cold_o
);
  logic hold_q, hold_d, err_q, err_d, rel_try;

  assign rel_try = wr_ctrl_i & wr_rel_i;
  assign cold_o  = first_i & pin_low_i;

  always_comb begin
    hold_d = hold_q;
    if (cold_o)                  hold_d = 1'b1;
    else if (rel_try && !lock_i) hold_d = 1'b0;
  end

  always_comb begin
    err_d = err_q;
    if (wr_ctrl_i && wr_clr_i) err_d = 1'b0;
    if (rel_try && lock_i)     err_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      hold_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      err_q  <= err_d;
    end
  end

  assign hold_o   = hold_q;
  assign hold_d_o = hold_d;
  assign err_o    = err_q;

  assert_release_clears_R3: assert property (@(posedge clk) disable iff (rst_i)
    (wr_ctrl_i && wr_rel_i && !lock_i && !first_i) |=> !hold_q);
  assert_zero_write_noop_R4: assert property (@(posedge clk) disable iff (rst_i)
    (wr_ctrl_i && !wr_rel_i && !first_i) |=> (hold_q == $past(hold_q)));
  assert_lock_sets_err_R5: assert property (@(posedge clk) disable iff (rst_i)
    (wr_ctrl_i && wr_rel_i && lock_i) |=> err_q);
  assert_lock_keeps_hold_R5: assert property (@(posedge clk) disable iff (rst_i)
    (wr_ctrl_i && lock_i && hold_q) |=> hold_q);
endmodule

// File: rtl/dpd_probe_detect.sv
module dpd_probe_detect (
  input  logic clk,
  input  logic rst_i,
  input  logic first_i,
  input  logic fall_i,
  input  logic sel_dbg_i,
  input  logic cold_i,
  output logic hpav_o,
  output logic pres_o
);
  logic hpav_q, pres_q, hot;

  assign hot = fall_i & hpav_q & sel_dbg_i & ~first_i;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      hpav_q <= 1'b1;
      pres_q <= 1'b0;
    end else begin
      if (!sel_dbg_i)   hpav_q <= 1'b0;
      if (cold_i | hot) pres_q <= 1'b1;
    end
  end

  assign hpav_o = hpav_q;
  assign pres_o = pres_q;

  assert_hpav_sticky_R9: assert property (@(posedge clk) disable iff (rst_i)
    !hpav_q |=> !hpav_q);
  assert_present_sticky_R10: assert property (@(posedge clk) disable iff (rst_i)
    pres_q |=> pres_q);
  assert_cold_sets_present_R7: assert property (@(posedge clk) disable iff (rst_i)
    cold_i |=> pres_q);
endmodule

// File: rtl/dbg_attach_hold.sv
module dbg_attach_hold
  import dpd_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              ext_rst_i,
  input  logic              dbg_clk_i,
  input  logic              dbg_pin_sel_i,
  input  logic              sec_lock_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              cpu_reset_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

  logic sys_rst, first_q, cpu_rst_q;
  logic level, fall, wr_ctrl;
  logic hold, hold_d, err, cold, hpav, pres;
  logic [DATA_W-1:0] rd_q, rd_d;

  assign sys_rst = por_i | ext_rst_i;
  assign wr_ctrl = wr_en_i & (wr_addr_i == A_CTRL);

  always_ff @(posedge clk) begin
    if (sys_rst) first_q <= 1'b1;
    else         first_q <= 1'b0;
  end

  dpd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_i   (sys_rst),
    .pin_i   (dbg_clk_i),
    .level_o (level),
    .fall_o  (fall)
  );

  dpd_hold_ctrl u_hold (
    .clk       (clk),
    .rst_i     (sys_rst),
    .first_i   (first_q),
    .pin_low_i (~level),
    .lock_i    (sec_lock_i),
    .wr_ctrl_i (wr_ctrl),
    .wr_rel_i  (wr_data_i[BIT_HOLD]),
    .wr_clr_i  (wr_data_i[BIT_PERR]),
    .hold_o    (hold),
    .hold_d_o  (hold_d),
    .err_o     (err),
    .cold_o    (cold)
  );

  dpd_probe_detect u_probe (
    .clk       (clk),
    .rst_i     (sys_rst),
    .first_i   (first_q),
    .fall_i    (fall),
    .sel_dbg_i (dbg_pin_sel_i),
    .cold_i    (cold),
    .hpav_o    (hpav),
    .pres_o    (pres)
  );

  always_ff @(posedge clk) begin
    cpu_rst_q <= sys_rst | hold_d;
  end

  always_comb begin
    rd_d = '0;
    if (rd_addr_i == A_CTRL) begin
      rd_d[BIT_HOLD] = hold;
      rd_d[BIT_PERR] = err;
    end else if (rd_addr_i == A_STAT) begin
      rd_d[BIT_PRES] = pres;
      rd_d[BIT_HPAV] = hpav;
    end
  end

  always_ff @(posedge clk) begin
    if (sys_rst) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rd_data_o   = rd_q;
  assign cpu_reset_o = cpu_rst_q;

  assert_reset_holds_cpu_R1: assert property (@(posedge clk)
    sys_rst |=> cpu_reset_o);
  assert_hold_keeps_reset_R2: assert property (@(posedge clk) disable iff (sys_rst)
    (hold && !first_q) |-> cpu_reset_o);
endmodule

// File: tb/tb_dbg_attach_hold.sv
module tb_dbg_attach_hold;
  logic       clk = 1'b0;
  logic       por = 1'b1, ext = 1'b0, pin = 1'b1, sel = 1'b1, lock = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       cpu_rst;
  int         errors = 0, checks = 0;

  always #5 clk = ~clk;

  dbg_attach_hold dut (
    .clk(clk), .por_i(por), .ext_rst_i(ext), .dbg_clk_i(pin),
    .dbg_pin_sel_i(sel), .sec_lock_i(lock), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .cpu_reset_o(cpu_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  // use_ext selects the external reset input instead of power-on reset
  task automatic do_reset(input logic p, input logic use_ext);
    @(negedge clk); pin = p; sel = 1'b1;
    if (use_ext) ext = 1'b1; else por = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cpu reset during reset", cpu_rst, 1);
    por = 1'b0; ext = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic hold, err;
    // R1 reset state
    repeat (4) @(negedge clk);
    chk("R1 read during reset", rd_data, 0);
    por = 1'b0;
    @(negedge clk);
    chk("R2 pin high release", cpu_rst, 0);
    rd(2'd0, d); chk("R1 ctrl reset value", d, 8'h00);
    rd(2'd1, d); chk("R1 stat reset value", d, 8'h02);
    rd(2'd2, d); chk("R11 unused address", d, 8'h00);

    // sweep R2 R3 R4 R5 R6 R7 over pin level, lock and two writes
    for (int p = 0; p < 2; p++)
      for (int l = 0; l < 2; l++)
        for (int d1 = 0; d1 < 4; d1++)
          for (int d2 = 0; d2 < 4; d2++) begin
            do_reset(p[0], 1'b0);
            lock = l[0];
            hold = (p == 0);
            err  = 1'b0;
            chk("R2 hold at release", cpu_rst, hold);
            rd(2'd1, d); chk("R7 cold plug present", d[0], hold);
            wr(2'd0, 8'(d1));
            if (d1[0] && !l[0]) hold = 1'b0;
            err = (err & ~d1[1]) | (d1[0] & l[0]);
            chk("R3 R4 R5 cpu reset after write1", cpu_rst, hold);
            rd(2'd0, d); chk("R3 R4 R5 ctrl after write1", d, {6'd0, err, hold});
            wr(2'd0, 8'(d2));
            if (d2[0] && !l[0]) hold = 1'b0;
            err = (err & ~d2[1]) | (d2[0] & l[0]);
            chk("R6 cpu reset after write2", cpu_rst, hold);
            rd(2'd0, d); chk("R6 ctrl after write2", d, {6'd0, err, hold});
          end
    lock = 1'b0;

    // R8 hot plug
    do_reset(1'b1, 1'b0);
    rd(2'd1, d); chk("R8 no probe before edge", d, 8'h02);
    @(negedge clk); pin = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd1, d); chk("R8 hot plug present", d, 8'h03);
    chk("R8 hot plug no hold", cpu_rst, 0);
    // R10 writes to status ignored, only reset clears
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R10 status write ignored", d, 8'h03);
    wr(2'd0, 8'h00);
    rd(2'd1, d); chk("R10 present after ctrl write", d, 8'h03);
    do_reset(1'b1, 1'b1);
    rd(2'd1, d); chk("R10 ext reset clears present", d, 8'h02);

    // R9 pin function change disables hot plug until reset
    @(negedge clk); sel = 1'b0;
    @(negedge clk); sel = 1'b1;
    rd(2'd1, d); chk("R9 hot plug disabled", d, 8'h00);
    pin = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd1, d); chk("R9 edge ignored", d, 8'h00);
    // R9 edge in the same cycle as the switch is also ignored
    do_reset(1'b1, 1'b1);
    @(negedge clk); pin = 1'b0;
    repeat (2) @(negedge clk); sel = 1'b0;
    @(negedge clk); sel = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd1, d); chk("R9 colliding edge ignored", d, 8'h00);
    do_reset(1'b1, 1'b0);
    rd(2'd1, d); chk("R9 reset restores hot plug", d, 8'h02);

    // R11 read latency: value appears exactly one edge after address
    @(negedge clk); rd_addr = 2'd0;
    @(negedge clk); rd_addr = 2'd1;
    chk("R11 ctrl before latency", rd_data, 8'h00);
    @(negedge clk);
    chk("R11 stat after one edge", rd_data, 8'h02);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule